// File: doc/BRIEF.md
# Time-Slot Interchange Switch Core

This block switches byte-wide channels between serial time-division streams. Four input lines and four output lines each carry a repeating frame of eight 8-bit channel slots. Every received channel byte is stored in a data memory. Each output slot is then built from its own connection entry. That entry chooses one of four behaviours: a low-latency path that depends on the distance between the source and destination channels, a fixed two-frame path that keeps whole frames together, a byte supplied by the controlling processor, or an idle driver.

The controlling side fills the connection memory through a simple synchronous write port and can read any entry back. The data memory has three frame buffers. The buffer being written moves on at every frame boundary. The fixed-latency path reads the buffer that was filled two frames before the output frame. The low-latency path always reads the newest byte at the addressed location.

Top module: `tsi_core`

## Requirements
- R1: A high `frame_sync` during a clock marks that clock as bit 0 of channel 0. Each channel lasts 8 clocks and is shifted most significant bit first. Output slot c covers the same clocks as input slot c.
- R2: A connection entry is 16 bits wide. Bits [15:14] give the mode: 00 minimum-latency, 01 fixed-latency, 10 processor byte, 11 idle. For the two memory modes, bits [4:3] name the source line and bits [2:0] name the source channel. The entry for output line s, channel c sits at address s*8+c. After reset every entry reads 16'hC000.
- R3: During a slot whose entry is idle, that line's `tx_oe` is low and its `tx` is 0. Directly after reset all `tx_oe` are low.
- R4: In processor mode, bits [7:0] of the entry go out in that slot in every frame. A new value takes effect from the first frame after it is written, provided it is written before the slot's fetch (two slots ahead of the slot).
- R5: In minimum-latency mode, count slots globally as 8*frame+channel. A byte received in global slot g leaves in the earliest output slot at or after g+3. So channels n+3 and above get it in the same frame, and channels n..n+2 get it in the next frame.
- R6: The minimum-latency delay depends only on the two channel numbers. It does not change with the source or destination line.
- R7: In fixed-latency mode, a byte received in frame p leaves in frame p+2, whatever the channel pair. The shortest case is source channel 7 sent to output channel 0, which is one frame plus one slot.
- R8: The active write buffer changes only at the end of the last bit of channel 7, and it cycles through three buffers.
- R9: One clock after a write, the read port returns the written entry for that address.
- R10: `tx_oe` changes only at slot boundaries, so it is constant for all 8 bits of a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock; one serial bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | High for the first bit of channel 0 |
| rx | input | 4 | Serial input lines |
| tx | output | 4 | Serial output lines, 0 while disabled |
| tx_oe | output | 4 | Per-line driver enable for the current slot |
| cm_we | input | 1 | Connection memory write strobe |
| cm_waddr | input | 5 | Write address: line*8+channel |
| cm_wdata | input | 16 | Entry to write |
| cm_raddr | input | 5 | Read address: line*8+channel |
| cm_rdata | output | 16 | Entry at cm_raddr |

## Verification
At the last bit of every slot, three things happen in the same clock edge: input channel r is written, the entry for output channel r+2 is fetched, and the byte for channel r+1 is loaded. The bench sets up a minimum-latency connection whose source is exactly two channels ahead of its output. In that case the fetch and the write hit the same location at the same edge. The bench checks that the output carries the previous frame's byte, not the one arriving. The same is done for fixed-latency reads that wrap from channels 6 and 7 into the next frame. Those reads must pick the buffer two frames before the output frame even though the fetch happens in the frame before it.

// File: rtl/tsi_core.sv
module tsi_core #(
  parameter int STREAMS = 4,
  parameter int CHANS   = 8,
  parameter int BITS    = 8
) (
  input  logic                                 bit_clk,
  input  logic                                 rst_n,
  input  logic                                 frame_sync,
  input  logic [STREAMS-1:0]                   rx,
  output logic [STREAMS-1:0]                   tx,
  output logic [STREAMS-1:0]                   tx_oe,
  input  logic                                 cm_we,
  input  logic [$clog2(STREAMS*CHANS)-1:0]     cm_waddr,
  input  logic [15:0]                          cm_wdata,
  input  logic [$clog2(STREAMS*CHANS)-1:0]     cm_raddr,
  output logic [15:0]                          cm_rdata
);
  localparam int SW    = $clog2(STREAMS);
  localparam int CW    = $clog2(CHANS);
  localparam int BW    = $clog2(BITS);
  localparam int AW    = SW + CW;
  localparam int PW    = CW + BW;
  localparam int SLOTS = STREAMS * CHANS;
  localparam logic [1:0] M_CONST = 2'b01;
  localparam logic [1:0] M_PROC  = 2'b10;
  localparam logic [1:0] M_IDLE  = 2'b11;

  logic [PW-1:0]     pos_q;
  logic [1:0]        wbuf;
  logic [15:0]       cmem     [SLOTS];
  logic [BITS-1:0]   dmem     [3*SLOTS];
  logic [BITS-1:0]   rx_sh    [STREAMS];
  logic [BITS-1:0]   stage_q  [STREAMS];
  logic [BITS-1:0]   tx_sh    [STREAMS];
  logic [BITS-1:0]   fetch_byte [STREAMS];
  logic [STREAMS-1:0] stage_oe;
  logic [STREAMS-1:0] fetch_oe;
  logic [AW-1:0]     fi;
  logic [1:0]        sel;

  wire [PW-1:0] cur         = frame_sync ? '0 : pos_q;
  wire [CW-1:0] cur_ch      = cur[PW-1:BW];
  wire          slot_end    = &cur[BW-1:0];
  wire [CW-1:0] fetch_ch    = cur_ch + CW'(2);
  wire          fetch_wraps = cur_ch >= CW'(CHANS-2);
  wire [1:0]    buf_prev    = (wbuf == 2'd0) ? 2'd2 : wbuf - 2'd1;
  wire [1:0]    buf_next    = (wbuf == 2'd2) ? 2'd0 : wbuf + 2'd1;
  wire [1:0]    buf_const   = fetch_wraps ? buf_prev : buf_next;

  always_ff @(posedge bit_clk or negedge rst_n)
    if (!rst_n) begin
      pos_q <= '0;
      wbuf  <= '0;
    end else begin
      pos_q <= cur + PW'(1);
      if (&cur) wbuf <= buf_next;
    end

  always_ff @(posedge bit_clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) cmem[i] <= {M_IDLE, 14'd0};
    end else if (cm_we) begin
      cmem[cm_waddr] <= cm_wdata;
    end

  assign cm_rdata = cmem[cm_raddr];

  always_ff @(posedge bit_clk)
    for (int s = 0; s < STREAMS; s++) begin
      rx_sh[s] <= {rx_sh[s][BITS-2:0], rx[s]};
      if (slot_end) dmem[{wbuf, SW'(s), cur_ch}] <= {rx_sh[s][BITS-2:0], rx[s]};
    end

  always_comb begin
    fi  = '0;
    sel = '0;
    for (int s = 0; s < STREAMS; s++) begin
      fi  = {SW'(s), fetch_ch};
      sel = (cmem[fi][CW-1:0] < cur_ch) ? wbuf : buf_prev;
      if (cmem[fi][15:14] == M_CONST) sel = buf_const;
      fetch_byte[s] = (cmem[fi][15:14] == M_PROC) ? cmem[fi][BITS-1:0]
                                                  : dmem[{sel, cmem[fi][AW-1:0]}];
      fetch_oe[s]   = cmem[fi][15:14] != M_IDLE;
    end
  end

  always_ff @(posedge bit_clk or negedge rst_n)
    if (!rst_n) begin
      stage_oe <= '0;
      tx_oe    <= '0;
      for (int s = 0; s < STREAMS; s++) begin
        stage_q[s] <= '0;
        tx_sh[s]   <= '0;
      end
    end else if (slot_end) begin
      tx_oe    <= stage_oe;
      stage_oe <= fetch_oe;
      for (int s = 0; s < STREAMS; s++) begin
        tx_sh[s]   <= stage_q[s];
        stage_q[s] <= fetch_byte[s];
      end
    end else begin
      for (int s = 0; s < STREAMS; s++) tx_sh[s] <= tx_sh[s] << 1;
    end

  for (genvar s = 0; s < STREAMS; s++) begin : g_tx
    assign tx[s] = tx_oe[s] & tx_sh[s][BITS-1];
  end
endmodule

// File: rtl/tsi_core_checker.sv
module tsi_core_checker #(
  parameter int STREAMS = 4,
  parameter int CHANS   = 8,
  parameter int BITS    = 8
) (
  input logic                                bit_clk,
  input logic                                rst_n,
  input logic [STREAMS-1:0]                  tx_oe,
  input logic [$clog2(CHANS)+$clog2(BITS)-1:0] pos_q,
  input logic [1:0]                          wbuf,
  input logic                                cm_we,
  input logic [$clog2(STREAMS*CHANS)-1:0]    cm_waddr,
  input logic [15:0]                         cm_wdata,
  input logic [$clog2(STREAMS*CHANS)-1:0]    cm_raddr,
  input logic [15:0]                         cm_rdata
);
  localparam int BW = $clog2(BITS);

  assert_oe_slot_stable_R10: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (pos_q[BW-1:0] != '0) |-> $stable(tx_oe));

  assert_buf_rotate_R8: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (wbuf != $past(wbuf)) |-> (pos_q == '0));

  assert_cm_readback_R9: assert property (@(posedge bit_clk) disable iff (!rst_n)
    ($past(cm_we) && (cm_raddr == $past(cm_waddr))) |-> (cm_rdata == $past(cm_wdata)));

  assert_reset_idle_R3: assert property (@(posedge bit_clk) disable iff (!rst_n)
    $rose(rst_n) |-> (tx_oe == '0));
endmodule

bind tsi_core tsi_core_checker #(.STREAMS(STREAMS), .CHANS(CHANS), .BITS(BITS)) u_chk (
  .bit_clk(bit_clk), .rst_n(rst_n), .tx_oe(tx_oe), .pos_q(pos_q), .wbuf(wbuf),
  .cm_we(cm_we), .cm_waddr(cm_waddr), .cm_wdata(cm_wdata),
  .cm_raddr(cm_raddr), .cm_rdata(cm_rdata));

// File: tb/tsi_core_test.sv
module tsi_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fs = 1'b0;
  logic [3:0]  rx = '0;
  logic [3:0]  tx, oe;
  logic        cm_we = 1'b0;
  logic [4:0]  cm_waddr = '0, cm_raddr = '0;
  logic [15:0] cm_wdata = '0;
  logic [15:0] cm_rdata;
  int errors = 0;
  int checks = 0;
  logic [7:0] gb, eb;
  logic       eo;
  logic [7:0] cap_byte [4][8];
  logic       cap_oe   [4][8];
  logic       oe_moved [4][8];

  always #4 clk = ~clk;

  tsi_core uut (.bit_clk(clk), .rst_n(rst_n), .frame_sync(fs), .rx(rx), .tx(tx), .tx_oe(oe),
                .cm_we(cm_we), .cm_waddr(cm_waddr), .cm_wdata(cm_wdata),
                .cm_raddr(cm_raddr), .cm_rdata(cm_rdata));

  function automatic logic [7:0] gen(int f, int s, int c);
    return 8'((f * 53 + s * 29 + c * 7 + 1) & 255);
  endfunction

  function automatic logic [23:0] row(int ph, int os, int oc, int md, int ss, int sc, int pb);
    return {ph[0], os[1:0], oc[2:0], md[1:0], ss[1:0], sc[2:0], 3'b000, pb[7:0]};
  endfunction

  function automatic logic [15:0] entry_of(logic [23:0] v);
    return (v[17:16] == 2'b10) ? {2'b10, 6'd0, v[7:0]} : {v[17:16], 9'd0, v[15:14], v[13:11]};
  endfunction

  function automatic string req_of(logic [23:0] v);
    case (v[17:16])
      2'b00:   return (v[22:21] != v[15:14]) ? "R1 R5 R6" : "R1 R5";
      2'b01:   return "R7";
      2'b10:   return "R4";
      default: return "R3";
    endcase
  endfunction

  localparam int NV = 14;
  localparam logic [23:0] VEC [NV] = '{
    row(0, 0, 5, 0, 0, 2, 0),
    row(0, 0, 4, 0, 1, 2, 0),
    row(0, 0, 2, 0, 2, 2, 0),
    row(0, 0, 0, 0, 3, 5, 0),
    row(0, 1, 0, 0, 0, 6, 0),
    row(0, 1, 3, 0, 1, 7, 0),
    row(0, 1, 7, 1, 0, 0, 0),
    row(0, 2, 0, 1, 3, 7, 0),
    row(0, 2, 1, 1, 2, 7, 0),
    row(0, 2, 6, 2, 0, 0, 'hA5),
    row(0, 3, 3, 2, 0, 0, 'h3C),
    row(0, 3, 4, 3, 0, 0, 0),
    row(1, 3, 3, 2, 0, 0, 'h81),
    row(1, 2, 6, 1, 1, 4, 0)
  };

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cm_write(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    cm_we = 1'b1; cm_waddr = a; cm_wdata = d;
    @(negedge clk);
    cm_we = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(oe == 4'h0, "R3", "oe after reset", oe, 0);
    check(tx == 4'h0, "R3", "tx after reset", tx, 0);
    cm_raddr = 5'd31;
    #1 check(cm_rdata == 16'hC000, "R2", "default entry", cm_rdata, 16'hC000);

    for (int i = 0; i < NV; i++)
      if (VEC[i][23] == 1'b0) cm_write({VEC[i][22:21], VEC[i][20:18]}, entry_of(VEC[i]));
    for (int i = 0; i < 12; i += 5) begin
      cm_raddr = {VEC[i][22:21], VEC[i][20:18]};
      #1 check(cm_rdata == entry_of(VEC[i]), "R9 R2", "readback", cm_rdata, entry_of(VEC[i]));
    end

    for (int f = 0; f < 8; f++) begin
      for (int pos = 0; pos < 64; pos++) begin
        @(negedge clk);
        fs = (pos == 0);
        if (f == 6 && pos < 2) begin
          cm_we = 1'b1;
          cm_waddr = {VEC[12 + pos][22:21], VEC[12 + pos][20:18]};
          cm_wdata = entry_of(VEC[12 + pos]);
        end else begin
          cm_we = 1'b0;
        end
        for (int s = 0; s < 4; s++) begin
          gb = gen(f, s, pos / 8);
          rx[s] = gb[7 - (pos % 8)];
        end
        #1;
        for (int s = 0; s < 4; s++) begin
          if (pos % 8 == 0) begin
            cap_oe[s][pos / 8] = oe[s];
            oe_moved[s][pos / 8] = 1'b0;
          end else if (oe[s] != cap_oe[s][pos / 8]) begin
            oe_moved[s][pos / 8] = 1'b1;
          end
          cap_byte[s][pos / 8][7 - (pos % 8)] = tx[s];
        end
      end
      if (f >= 3) begin
        for (int i = 0; i < NV; i++) begin
          if ((VEC[i][23] == 1'b0 && f < 6) || (VEC[i][23] == 1'b1 && f >= 6)) begin
            eo = 1'b1;
            case (VEC[i][17:16])
              2'b00: eb = gen((8 * f + int'(VEC[i][20:18]) - 3 - int'(VEC[i][13:11])) / 8,
                              int'(VEC[i][15:14]), int'(VEC[i][13:11]));
              2'b01: eb = gen(f - 2, int'(VEC[i][15:14]), int'(VEC[i][13:11]));
              2'b10: eb = VEC[i][7:0];
              default: begin eb = 8'h00; eo = 1'b0; end
            endcase
            check(cap_byte[VEC[i][22:21]][VEC[i][20:18]] == eb, req_of(VEC[i]), "slot byte",
                  cap_byte[VEC[i][22:21]][VEC[i][20:18]], eb);
            check(cap_oe[VEC[i][22:21]][VEC[i][20:18]] == eo, req_of(VEC[i]), "slot enable",
                  cap_oe[VEC[i][22:21]][VEC[i][20:18]], eo);
          end
        end
        check(cap_oe[3][7] == 1'b0 && cap_byte[3][7] == 8'h00, "R3", "unwritten slot idle",
              {cap_oe[3][7], cap_byte[3][7]}, 0);
        for (int s = 0; s < 4; s++)
          for (int c = 0; c < 8; c++)
            check(!oe_moved[s][c], "R10", "enable moved inside slot", oe_moved[s][c], 0);
      end
    end

    @(negedge clk);
    fs = 1'b0;
    cm_raddr = 5'd27;
    #1 check(cm_rdata == 16'h8081, "R4", "changed processor entry", cm_rdata, 16'h8081);
    rst_n = 1'b0;
    #1;
    check(cm_rdata == 16'hC000, "R2", "entry after mid-run reset", cm_rdata, 16'hC000);
    check(oe == 4'h0 && tx == 4'h0, "R3", "lines after mid-run reset", {oe, tx}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(oe == 4'h0, "R3", "oe after release", oe, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule